// File: doc/BRIEF.md
# Key-Sequence Service Watchdog

This block is a countdown supervisor that software must arm and then service at regular intervals. After a system reset it sits idle. Software writes a 32-bit arming word to the control register, and from then on a 25-bit down counter decrements once per functional-clock tick. Software services the supervisor by writing a fixed pair of 16-bit words to the key register. That pair restores the counter from a 12-bit preload. If the counter is allowed to reach zero, or if software writes any key word the checker does not expect, the block raises a reset request. The request stays high until the system reset returns.

All registers sit behind a simple strobe-based write port and a combinational read port, both on the interface clock. The functional clock appears only as a per-cycle tick enable. When the tick is held low, counting stops and the block cannot expire. Once armed, the block cannot be disarmed by software.

Top module: `keyseq_watchdog`

## Requirements
- R1: After rst_n is low at a clock edge, register 0 reads 0 (disarmed), register 1 reads 0, register 3 reads 32'h01FFFFFF, and rst_req is 0.
- R2: A write of exactly 32'hA98559DA to register 0 arms the block, after which register 0 reads 1 in bit 0. Any other value written to register 0 leaves the block disarmed.
- R3: Once armed, no write to register 0 disarms the block. Only rst_n returns it to the disarmed state.
- R4: While armed, the counter in register 3 (bits 24:0) decreases by one at each edge where tick is 1. It holds its value at edges where tick is 0. While disarmed it holds its value regardless of tick.
- R5: Register 1 may be written at any time and reads back the low 12 bits of the written data. Writing it does not change the counter.
- R6: While armed, a key write (register 2, low 16 bits) of 16'hE51A followed by 16'hA35C loads the counter with {preload, 13'h1FFF}. The load becomes visible three cycles after the cycle that carries the A35C write, and not earlier.
- R7: While armed, a key write whose low 16 bits are not the next expected word raises rst_req three cycles after the write cycle.
- R8: While E51A is pending, a repeated E51A restarts the pair without an error. After a completed pair, the checker again expects E51A, so a lone A35C raises rst_req.
- R9: Key writes of any value while disarmed are ignored: there is no reset request and no counter change.
- R10: rst_req rises at the same edge at which a tick brings the counter to zero. From a reload with preload P this takes (P+1)*8192-1 ticks.
- R11: rst_req is sticky until rst_n. rst_n clears rst_req and also disarms the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 2 | Write register select: 0 control, 1 preload, 2 key, 3 counter (read-only) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register select, same map as wr_addr |
| rd_data | output | 32 | Combinational read data for rd_addr |
| tick | input | 1 | Functional-clock enable, one count step per high cycle |
| rst_req | output | 1 | Sticky reset request |

## Verification
The key checker is exercised with four kinds of word streams. A clean pair shows that the reload happens and lands in the right cycle. A pair with a repeated first word separates the restart rule from an error. A lone second word shows that the checker returns to its initial state after a pair. A first word followed by a foreign word shows immediate error detection. The counter is run with ticks both high and low, and run all the way to zero from the smallest preload, which separates freezing from counting and places the expiry on its exact tick. The bench also samples one cycle before each key effect is due, which catches a pipeline that is too short.

// File: rtl/wdg_pkg.sv
// Shared register map, key-beat record and checker states for the
// key-sequence watchdog. Assumes a 32-bit register data path and 16-bit keys.
package wdg_pkg;
    localparam int DATA_W = 32;
    localparam int KEY_W  = 16;

    typedef enum logic [1:0] {
        REG_CTRL    = 2'd0,
        REG_PRELOAD = 2'd1,
        REG_KEY     = 2'd2,
        REG_COUNT   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_HALF = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic             vld;
        logic [KEY_W-1:0] word;
    } key_beat_t;
endpackage

// File: rtl/wdg_arm_latch.sv
// One-way arming latch. It sets on a control write that carries the exact
// arming word and clears only on the system reset.
// Assumes wr_ctrl is a single-cycle qualified write strobe.
module wdg_arm_latch
    import wdg_pkg::*;
#(
    parameter logic [DATA_W-1:0] ARM_WORD = 32'hA98559DA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wr_data,
    output logic              armed
);
    // Latch the armed state; no path clears it apart from reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (wr_ctrl && (wr_data == ARM_WORD)) begin
            armed <= 1'b1;
        end
    end
endmodule

// File: rtl/wdg_key_seq.sv
// Key-write pipeline and two-word sequence checker. A key write is delayed
// through KEY_LAT-1 register stages. The checker then acts on it
// combinationally, so its effect lands at the KEY_LAT-th edge counted from
// the capturing edge. Writes made while disarmed never enter the pipeline.
// Assumes KEY_LAT >= 2.
module wdg_key_seq
    import wdg_pkg::*;
#(
    parameter int               KEY_LAT    = 3,
    parameter logic [KEY_W-1:0] KEY_FIRST  = 16'hE51A,
    parameter logic [KEY_W-1:0] KEY_SECOND = 16'hA35C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic             wr_key,
    input  logic [KEY_W-1:0] key_in,
    output logic             reload,
    output logic             key_err
);
    localparam int STAGES = KEY_LAT - 1;

    key_beat_t [STAGES-1:0] pipe;
    key_beat_t              beat;
    seq_state_e             state, state_nxt;

    // Shift key writes through the latency pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe[0].vld  <= wr_key && armed;
            pipe[0].word <= key_in;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign beat = pipe[STAGES-1];

    // Decide the checker's next state and its reload or error output.
    always_comb begin
        state_nxt = state;
        reload    = 1'b0;
        key_err   = 1'b0;
        if (beat.vld) begin
            unique case (state)
                SEQ_IDLE: begin
                    if (beat.word == KEY_FIRST) begin
                        state_nxt = SEQ_HALF;
                    end else begin
                        key_err = 1'b1;
                    end
                end
                SEQ_HALF: begin
                    if (beat.word == KEY_SECOND) begin
                        reload    = 1'b1;
                        state_nxt = SEQ_IDLE;
                    end else if (beat.word == KEY_FIRST) begin
                        state_nxt = SEQ_HALF;
                    end else begin
                        key_err   = 1'b1;
                        state_nxt = SEQ_IDLE;
                    end
                end
                default: state_nxt = SEQ_IDLE;
            endcase
        end
    end

    // Hold the checker state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
        end else begin
            state <= state_nxt;
        end
    end
endmodule

// File: rtl/wdg_down_counter.sv
// Down counter that decrements on functional ticks while the block is armed.
// A reload places the preload in the top bits and fills the low bits with
// ones. The expire output flags the tick that brings the count to zero.
// The counter rests at all ones after reset and stops at zero.
module wdg_down_counter #(
    parameter int CNT_W = 25,
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic             tick,
    input  logic             reload,
    input  logic [PRE_W-1:0] preload,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam int LOW_W = CNT_W - PRE_W;

    logic [CNT_W-1:0] reload_val;

    // Build the reload image: preload on top, the fill pattern below.
    generate
        if (LOW_W > 0) begin : g_fill
            assign reload_val = {preload, {LOW_W{1'b1}}};
        end else begin : g_direct
            assign reload_val = preload[CNT_W-1:0];
        end
    endgenerate

    // Count down, giving a reload priority over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '1;
        end else if (reload) begin
            count <= reload_val;
        end else if (armed && tick && (count != '0)) begin
            count <= count - 1'b1;
        end
    end

    // Flag the decrement that lands on zero.
    assign expire = armed && tick && !reload && (count == CNT_W'(1));
endmodule

// File: rtl/keyseq_watchdog.sv
// Top level of the key-sequence watchdog. It decodes register writes, keeps
// the preload, merges the key error and counter expiry into a sticky reset
// request, and drives the read mux. Assumes one write per cycle and a tick
// that is synchronous to clk.
module keyseq_watchdog
    import wdg_pkg::*;
#(
    parameter int                CNT_W      = 25,
    parameter int                PRE_W      = 12,
    parameter int                KEY_LAT    = 3,
    parameter logic [DATA_W-1:0] ARM_WORD   = 32'hA98559DA,
    parameter logic [KEY_W-1:0]  KEY_FIRST  = 16'hE51A,
    parameter logic [KEY_W-1:0]  KEY_SECOND = 16'hA35C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tick,
    output logic              rst_req
);
    logic             wr_ctrl, wr_pre, wr_key;
    logic             armed, reload, key_err, expire;
    logic [PRE_W-1:0] preload_q;
    logic [CNT_W-1:0] count;

    // Decode the write strobe per register.
    always_comb begin
        wr_ctrl = wr_en && (reg_sel_e'(wr_addr) == REG_CTRL);
        wr_pre  = wr_en && (reg_sel_e'(wr_addr) == REG_PRELOAD);
        wr_key  = wr_en && (reg_sel_e'(wr_addr) == REG_KEY);
    end

    wdg_arm_latch #(.ARM_WORD(ARM_WORD)) u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wr_data (wr_data),
        .armed   (armed)
    );

    wdg_key_seq #(
        .KEY_LAT    (KEY_LAT),
        .KEY_FIRST  (KEY_FIRST),
        .KEY_SECOND (KEY_SECOND)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (armed),
        .wr_key  (wr_key),
        .key_in  (wr_data[KEY_W-1:0]),
        .reload  (reload),
        .key_err (key_err)
    );

    wdg_down_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (armed),
        .tick    (tick),
        .reload  (reload),
        .preload (preload_q),
        .count   (count),
        .expire  (expire)
    );

    // Keep the preload; writable in any state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preload_q <= '0;
        end else if (wr_pre) begin
            preload_q <= wr_data[PRE_W-1:0];
        end
    end

    // Latch the reset request until the system reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
        end else if (key_err || expire) begin
            rst_req <= 1'b1;
        end
    end

    // Select the read data.
    always_comb begin
        unique case (reg_sel_e'(rd_addr))
            REG_CTRL:    rd_data = {{(DATA_W-1){1'b0}}, armed};
            REG_PRELOAD: rd_data = {{(DATA_W-PRE_W){1'b0}}, preload_q};
            REG_COUNT:   rd_data = {{(DATA_W-CNT_W){1'b0}}, count};
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/wdg_checker.sv
// Property checker for the key-sequence watchdog, bound to the top module.
module wdg_checker #(
    parameter int CNT_W = 25,
    parameter int PRE_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             armed,
    input logic             tick,
    input logic             reload,
    input logic             key_err,
    input logic             rst_req,
    input logic [CNT_W-1:0] count,
    input logic [PRE_W-1:0] preload
);
    localparam int LOW_W = CNT_W - PRE_W;

    p_arm_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);

    p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !reload) |=> (count == $past(count)));

    p_reload_val_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (count == {$past(preload), {LOW_W{1'b1}}}));

    p_err_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        key_err |=> rst_req);

    p_quiet_disarmed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !rst_req);

    p_zero_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (count == '0)) |-> rst_req);

    p_req_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);
endmodule

bind keyseq_watchdog wdg_checker #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .armed   (armed),
    .tick    (tick),
    .reload  (reload),
    .key_err (key_err),
    .rst_req (rst_req),
    .count   (count),
    .preload (preload_q)
);

// File: tb/keyseq_watchdog_test.sv
// Scoreboard bench: driver tasks queue expected items, a monitor compares.
module keyseq_watchdog_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [31:0] rd_data;
    logic        tick = 1'b0;
    logic        rst_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;   // 0: read register, 1: rst_req
        logic [1:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    item_t cur;
    logic [31:0] act;

    keyseq_watchdog uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .tick    (tick),
        .rst_req (rst_req)
    );

    always #5 clk = ~clk;

    // Monitor: pop expected items and compare them with the design.
    initial begin
        forever begin
            wait (sbq.size() > 0);
            cur = sbq.pop_front();
            if (cur.kind == 0) begin
                rd_addr = cur.addr;
                #1;
                act = rd_data;
            end else begin
                #1;
                act = {31'd0, rst_req};
            end
            n_chk++;
            if (act !== cur.exp) begin
                n_bad++;
                $display("FAIL %s: actual=%h expected=%h", cur.tag, act, cur.exp);
            end
        end
    end

    task automatic push_item(input int kind, input logic [1:0] addr,
                             input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.addr = addr; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
        wait (sbq.size() == 0);
        #2;
    endtask

    task automatic chk_rd(input logic [1:0] addr, input logic [31:0] exp, input string tag);
        push_item(0, addr, exp, tag);
    endtask

    task automatic chk_req(input logic exp, input string tag);
        push_item(1, 2'd0, {31'd0, exp}, tag);
    endtask

    task automatic wr(input logic [1:0] addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; tick = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1: reset state
        chk_rd(2'd0, 32'h0, "R1 ctrl after reset");
        chk_rd(2'd1, 32'h0, "R1 preload after reset");
        chk_rd(2'd3, 32'h01FFFFFF, "R1 counter after reset");
        chk_req(1'b0, "R1 rst_req after reset");

        // R9: key writes while disarmed are ignored
        wr(2'd2, 32'h0000E51A);
        wr(2'd2, 32'h00001234);
        repeat (3) step();
        chk_req(1'b0, "R9 no request from keys while disarmed");
        chk_rd(2'd3, 32'h01FFFFFF, "R9 counter untouched while disarmed");

        // R4: ticks while disarmed do nothing
        ticks(5);
        chk_rd(2'd3, 32'h01FFFFFF, "R4 counter holds while disarmed");

        // R2: a near-miss arming word does not arm
        wr(2'd0, 32'hA98559DB);
        chk_rd(2'd0, 32'h0, "R2 wrong arming word ignored");
        // R5: preload keeps the low 12 bits
        wr(2'd1, 32'h0000FFF3);
        chk_rd(2'd1, 32'h00000FF3, "R5 preload readback");
        wr(2'd1, 32'h2);
        // R2: exact arming word arms
        wr(2'd0, 32'hA98559DA);
        chk_rd(2'd0, 32'h1, "R2 armed");

        // R4: count with ticks, then freeze
        ticks(10);
        chk_rd(2'd3, 32'h01FFFFF5, "R4 ten ticks counted");
        repeat (4) step();
        chk_rd(2'd3, 32'h01FFFFF5, "R4 frozen without ticks");

        // R3: writes to control cannot disarm
        wr(2'd0, 32'h0);
        chk_rd(2'd0, 32'h1, "R3 still armed after control write");

        // R6: clean pair reloads, exactly three cycles after the write
        wr(2'd2, 32'h0000E51A);
        wr(2'd2, 32'h0000A35C);
        chk_rd(2'd3, 32'h01FFFFF5, "R6 no reload one cycle after write");
        step();
        chk_rd(2'd3, 32'h01FFFFF5, "R6 no reload two cycles after write");
        step();
        chk_rd(2'd3, 32'h00005FFF, "R6 reload to {2,1FFF}");

        // R5: preload write does not touch the counter
        wr(2'd1, 32'h5);
        chk_rd(2'd3, 32'h00005FFF, "R5 counter unchanged by preload write");

        // R8: repeated first word restarts the pair
        ticks(3);
        wr(2'd2, 32'h0000E51A);
        wr(2'd2, 32'h0000E51A);
        repeat (2) step();
        chk_req(1'b0, "R8 repeated E51A is not an error");
        chk_rd(2'd3, 32'h00005FFC, "R8 no reload before second word");
        wr(2'd2, 32'h0000A35C);
        repeat (2) step();
        chk_rd(2'd3, 32'h0000BFFF, "R8 reload after restarted pair");
        chk_req(1'b0, "R8 no request after restarted pair");

        // R10: expiry from preload 0
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h0000E51A);
        wr(2'd2, 32'h0000A35C);
        repeat (2) step();
        chk_rd(2'd3, 32'h00001FFF, "R10 reload to 1FFF");
        ticks(8190);
        chk_rd(2'd3, 32'h00000001, "R10 one tick left");
        chk_req(1'b0, "R10 no request before zero");
        ticks(1);
        chk_rd(2'd3, 32'h00000000, "R10 counter at zero");
        chk_req(1'b1, "R10 request at zero");

        // R11: sticky until reset, reset disarms
        repeat (5) step();
        chk_req(1'b1, "R11 request sticky");
        do_reset();
        chk_req(1'b0, "R11 request cleared by reset");
        chk_rd(2'd0, 32'h0, "R11 disarmed by reset");

        // R8: lone second word after reset is an error
        wr(2'd0, 32'hA98559DA);
        wr(2'd2, 32'h0000A35C);
        step();
        chk_req(1'b0, "R8 lone A35C not yet effective");
        step();
        chk_req(1'b1, "R8 lone A35C raises request");

        // R7: foreign word after first word
        do_reset();
        wr(2'd0, 32'hA98559DA);
        wr(2'd2, 32'h0000E51A);
        wr(2'd2, 32'h0000BEEF);
        step();
        chk_req(1'b0, "R7 error not yet effective");
        step();
        chk_req(1'b1, "R7 wrong key raises request");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule